// File: doc/BRIEF.md
# Byte-Lane Synchronous RAM Access Port

This block is one clocked access port onto a word-wide memory array whose words are split into two 9-bit byte lanes. Address, write data and every control input are captured on the rising edge of the clock. A selected write updates only the lanes whose lane selects are asserted. A selected read returns the addressed word, and a per-lane drive-enable flag says which lanes would actually be driving a shared bus. This stands in for tri-state pins.

The port is selected only when two chip enables of opposite polarity agree. A mode pin sets the read latency. In flow-through mode, data appears in the cycle that follows the capturing edge. In two-stage mode, the data passes through an extra register and appears one cycle later. In two-stage mode the select and read/write decision also travel through that extra stage, but the lane selects are sampled only once. A lane that should drive in that mode must therefore have its select asserted on the edge after the address. A quiet pin removes all drive at once, without waiting for a clock edge.

The data path has no back-pressure. The port accepts one request on every clock edge and has no valid/ready handshake, so every pin here is a plain control or data pin. The array depth is set by `ADDR_W`. The full-size configuration uses `ADDR_W = 14` (16384 words). The default is smaller.

Top module: `lane_sram_port`

## Requirements
- R1: The array holds 2**ADDR_W words of 18 bits. The upper lane is bits 17:9 and is governed by `lane_n[1]`. The lower lane is bits 8:0 and is governed by `lane_n[0]`. Every address from 0 to 2**ADDR_W-1 is reachable, including the highest.
- R2: The port is selected on an edge only if `en_a_n` is 0 and `en_b` is 1. An edge that captures any other combination writes nothing. The cycle that request governs has `drv_en` = 2'b00.
- R3: On an edge where the port is selected and `write_n` is 0, each lane whose `lane_n` bit is 0 takes its slice of `wdata`. Each lane whose bit is 1 keeps its old contents.
- R4: A selected request with `lane_n` = 2'b11 writes nothing and makes no lane drive.
- R5: In flow-through mode (`two_stage` = 0), a selected read captured on edge k drives, in the cycle after edge k, exactly the lanes whose `lane_n` bit was 0 on edge k. The read carries the word stored at the captured address, including any write made on an earlier edge.
- R6: In two-stage mode (`two_stage` = 1), the data and the select/read decision captured on edge k appear in the cycle after edge k+1. The data is the word as it stood before edge k+1. The lane mask used in that cycle is the one captured on edge k+1, so a deselect takes two edges to remove drive.
- R7: While `out_quiet` is 1, `drv_en` is 2'b00 at once, without waiting for a clock edge. Writes are not affected by `out_quiet`.
- R8: A lane whose `drv_en` bit is 0 shows 0 on its slice of `rdata`.
- R9: While `rst_n` is 0 and until the first selected read, `drv_en` is 2'b00 and `rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the capture and output registers |
| two_stage | input | 1 | 1 = two-cycle read latency, 0 = flow-through |
| en_a_n | input | 1 | Active-low chip enable |
| en_b | input | 1 | Active-high chip enable |
| write_n | input | 1 | 0 = write, 1 = read |
| lane_n | input | 2 | Active-low lane selects; bit 1 upper, bit 0 lower |
| out_quiet | input | 1 | Asynchronous drive disable, active high |
| addr | input | ADDR_W | Word address |
| wdata | input | 18 | Write data |
| rdata | output | 18 | Read data, zero in non-driving lanes |
| drv_en | output | 2 | Per-lane drive flag; bit 1 upper, bit 0 lower |

## Verification
Full-word writes followed by full, upper-only and lower-only reads separate correct lane steering from swapped or merged lanes. Partial writes, writes with both lane selects high, and writes with each chip enable wrong in turn show whether the write gate honours every term of its condition. In two-stage mode, reads that change the lane mask or drop the select on the following edge tell the once-sampled lane path apart from the twice-sampled enable path. Long pseudo-random mixes in both modes, with `out_quiet` toggled inside cycles, are compared cycle by cycle against a behavioural model that tracks the memory and the latency of each mode.

// File: rtl/sp_pkg.sv
package sp_pkg;
  // Decision captured for one request: port selected and request is a read.
  typedef struct packed {
    logic sel;
    logic rd;
  } sp_ctl_t;
endpackage

// File: rtl/sp_capture.sv
module sp_capture
  import sp_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_a_n,
  input  logic              en_b,
  input  logic              write_n,
  input  logic [LANES-1:0]  lane_n,
  input  logic [ADDR_W-1:0] addr,
  output sp_ctl_t           ctl_q,
  output logic [LANES-1:0]  lane_n_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [LANES-1:0]  wr_lane
);
  logic sel_now;
  assign sel_now = !en_a_n && en_b;

  // Per-lane write strobes, acted on by the array at this same edge.
  for (genvar g = 0; g < LANES; g++) begin : g_wr
    assign wr_lane[g] = sel_now && !write_n && !lane_n[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q    <= '0;
      lane_n_q <= '1;
      addr_q   <= '0;
    end else begin
      ctl_q.sel <= sel_now;
      ctl_q.rd  <= write_n;
      lane_n_q  <= lane_n;
      addr_q    <= addr;
    end
  end
endmodule

// File: rtl/sp_lane_array.sv
module sp_lane_array #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned LANE_W = 9,
  parameter int unsigned LANES  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LANES-1:0]        wr_lane,
  input  logic [ADDR_W-1:0]       waddr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [ADDR_W-1:0]       raddr,
  output logic [LANES*LANE_W-1:0] flow_data,
  output logic [LANES*LANE_W-1:0] pipe_data
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] store [DEPTH];
    logic [LANE_W-1:0] pipe_q;

    always_ff @(posedge clk) begin
      if (wr_lane[g]) store[waddr] <= wdata[g*LANE_W +: LANE_W];
    end

    // Second read stage: samples the word before this edge's write lands.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q <= '0;
      else        pipe_q <= store[raddr];
    end

    assign flow_data[g*LANE_W +: LANE_W] = store[raddr];
    assign pipe_data[g*LANE_W +: LANE_W] = pipe_q;
  end
endmodule

// File: rtl/sp_out_stage.sv
module sp_out_stage
  import sp_pkg::*;
#(
  parameter int unsigned LANE_W = 9,
  parameter int unsigned LANES  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    two_stage,
  input  logic                    out_quiet,
  input  sp_ctl_t                 ctl_q,
  input  logic [LANES-1:0]        lane_n_q,
  input  logic [LANES*LANE_W-1:0] flow_data,
  input  logic [LANES*LANE_W-1:0] pipe_data,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic [LANES-1:0]        drv_en
);
  sp_ctl_t                 ctl_q2;
  sp_ctl_t                 ctl_use;
  logic [LANES*LANE_W-1:0] data_use;

  // Enables get a second stage; lane selects do not.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q2 <= '0;
    else        ctl_q2 <= ctl_q;
  end

  assign ctl_use  = two_stage ? ctl_q2 : ctl_q;
  assign data_use = two_stage ? pipe_data : flow_data;

  for (genvar g = 0; g < LANES; g++) begin : g_out
    assign drv_en[g] = ctl_use.sel && ctl_use.rd && !lane_n_q[g] && !out_quiet;
    assign rdata[g*LANE_W +: LANE_W] = drv_en[g] ? data_use[g*LANE_W +: LANE_W] : '0;

    always_comb begin
      if (!drv_en[g]) begin
        assert_idle_lane_zero_R8: assert (rdata[g*LANE_W +: LANE_W] == '0)
          else $error("idle lane %0d shows data", g);
      end
    end
  end
endmodule

// File: rtl/lane_sram_port.sv
module lane_sram_port
  import sp_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned LANE_W = 9,
  parameter int unsigned LANES  = 2,
  localparam int unsigned DATA_W = LANE_W * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              two_stage,
  input  logic              en_a_n,
  input  logic              en_b,
  input  logic              write_n,
  input  logic [LANES-1:0]  lane_n,
  input  logic              out_quiet,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [LANES-1:0]  drv_en
);
  sp_ctl_t           ctl_q;
  logic [LANES-1:0]  lane_n_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LANES-1:0]  wr_lane;
  logic [DATA_W-1:0] flow_data;
  logic [DATA_W-1:0] pipe_data;

  sp_capture #(.ADDR_W(ADDR_W), .LANES(LANES)) u_capture (
    .clk(clk), .rst_n(rst_n), .en_a_n(en_a_n), .en_b(en_b),
    .write_n(write_n), .lane_n(lane_n), .addr(addr),
    .ctl_q(ctl_q), .lane_n_q(lane_n_q), .addr_q(addr_q), .wr_lane(wr_lane)
  );

  sp_lane_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_array (
    .clk(clk), .rst_n(rst_n), .wr_lane(wr_lane), .waddr(addr),
    .wdata(wdata), .raddr(addr_q), .flow_data(flow_data), .pipe_data(pipe_data)
  );

  sp_out_stage #(.LANE_W(LANE_W), .LANES(LANES)) u_out (
    .clk(clk), .rst_n(rst_n), .two_stage(two_stage), .out_quiet(out_quiet),
    .ctl_q(ctl_q), .lane_n_q(lane_n_q), .flow_data(flow_data),
    .pipe_data(pipe_data), .rdata(rdata), .drv_en(drv_en)
  );

  // Port-level view of selection, used only by the checks below.
  logic sel_in;
  assign sel_in = !en_a_n && en_b;

  assert_flow_deselect_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!two_stage && !$past(sel_in)) |-> drv_en == '0);

  assert_flow_read_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!two_stage && !out_quiet && $past(rst_n) &&
     $past(sel_in && write_n && lane_n == '0)) |-> drv_en == '1);

  assert_two_stage_deselect_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (two_stage && $past(two_stage) && $past(two_stage, 2) && !$past(sel_in, 2))
      |-> drv_en == '0);

  assert_quiet_no_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_quiet |-> drv_en == '0);
endmodule

// File: tb/lane_sram_port_tb_top.sv
`timescale 1ns/100ps
module lane_sram_port_tb_top;
  localparam int AW = 10;
  localparam int TOP_ADDR = (1 << AW) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        two_stage = 1'b0;
  logic        en_a_n = 1'b1;
  logic        en_b = 1'b0;
  logic        write_n = 1'b1;
  logic [1:0]  lane_n = 2'b11;
  logic        out_quiet = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [17:0] wdata = '0;
  logic [17:0] rdata;
  logic [1:0]  drv_en;

  always #2.5 clk = ~clk;

  lane_sram_port #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .two_stage(two_stage), .en_a_n(en_a_n),
    .en_b(en_b), .write_n(write_n), .lane_n(lane_n), .out_quiet(out_quiet),
    .addr(addr), .wdata(wdata), .rdata(rdata), .drv_en(drv_en)
  );

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;

  // Behavioural reference state.
  logic [17:0] mmem [int];
  bit          h_sel = 0, h_rd = 0;
  logic [1:0]  h_ln = 2'b11;
  int          h_addr = 0;
  bit          pp_sel = 0, pp_rd = 0;
  logic [17:0] pipe_val = '0;

  function automatic logic [17:0] mget(int a);
    return mmem.exists(a) ? mmem[a] : 18'h0;
  endfunction

  task automatic compare(input string tag);
    logic [17:0] val, exp_dat;
    logic [1:0]  exp_drv;
    bit act;
    val = two_stage ? pipe_val : mget(h_addr);
    act = two_stage ? (pp_sel && pp_rd) : (h_sel && h_rd);
    for (int l = 0; l < 2; l++) begin
      exp_drv[l] = act && !h_ln[l] && !out_quiet;
      exp_dat[l*9 +: 9] = exp_drv[l] ? val[l*9 +: 9] : 9'h0;
    end
    checks++;
    if (drv_en !== exp_drv || rdata !== exp_dat) begin
      failures++;
      $display("FAIL %s t=%0t drv_en act=%b exp=%b rdata act=%h exp=%h",
               tag, $time, drv_en, exp_drv, rdata, exp_dat);
    end
  endtask

  task automatic step(input logic a_n, input logic b, input logic wn,
                      input logic [1:0] ln, input int ad,
                      input logic [17:0] wd, input string tag);
    bit sel_new;
    en_a_n = a_n; en_b = b; write_n = wn; lane_n = ln;
    addr = AW'(ad); wdata = wd;
    @(posedge clk);
    sel_new  = !a_n && b;
    pipe_val = mget(h_addr);
    pp_sel   = h_sel;
    pp_rd    = h_rd;
    if (sel_new && !wn) begin
      logic [17:0] w;
      w = mget(ad);
      for (int l = 0; l < 2; l++) if (!ln[l]) w[l*9 +: 9] = wd[l*9 +: 9];
      mmem[ad] = w;
    end
    h_sel = sel_new; h_rd = wn; h_ln = ln; h_addr = ad;
    @(negedge clk);
    compare(tag);
  endtask

  task automatic wr(input int ad, input logic [17:0] wd, input logic [1:0] ln,
                    input string tag);
    step(1'b0, 1'b1, 1'b0, ln, ad, wd, tag);
  endtask

  task automatic rd(input int ad, input logic [1:0] ln, input string tag);
    step(1'b0, 1'b1, 1'b1, ln, ad, 18'h0, tag);
  endtask

  task automatic idle(input string tag);
    step(1'b1, 1'b0, 1'b1, 2'b11, 0, 18'h0, tag);
  endtask

  function automatic logic [17:0] pat(int i);
    return 18'(i * 1237 + 5 + (i << 11));
  endfunction

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      failures++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      summary();
      $finish;
    end
  end

  int unsigned rs = 32'h1234_5678;
  function automatic int unsigned rnd();
    rs ^= rs << 13; rs ^= rs >> 17; rs ^= rs << 5;
    return rs;
  endfunction

  task automatic random_mix(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      int unsigned r;
      r = rnd();
      out_quiet = (r[31:28] == 4'h0);
      step(r[0] & r[1], !(r[2] & r[3]), r[4] | r[5], r[7:6],
           int'(r[12:8]), 18'(r[30:13]), tag);
    end
    out_quiet = 1'b0;
  endtask

  initial begin
    // R9: reset state
    repeat (3) @(negedge clk);
    compare("R9");
    rst_n = 1'b1;
    idle("R9");

    // R3/R1: fill, including the top address
    for (int a = 0; a < 32; a++) wr(a, pat(a), 2'b00, "R3");
    wr(TOP_ADDR, 18'h2A5C3, 2'b00, "R1");
    rd(TOP_ADDR, 2'b00, "R1");
    rd(0, 2'b00, "R1");

    // R5: flow-through reads, full and masked
    for (int a = 0; a < 8; a++) rd(a, 2'b00, "R5");
    rd(9, 2'b10, "R5");
    rd(10, 2'b01, "R5");
    rd(11, 2'b01, "R8");
    rd(12, 2'b10, "R8");

    // R3: partial writes then reads
    wr(3, 18'h3FFFF, 2'b10, "R3");
    rd(3, 2'b00, "R3");
    wr(8, 18'h00000, 2'b01, "R3");
    rd(8, 2'b00, "R3");

    // R4: both lane selects high
    wr(4, 18'h15555, 2'b11, "R4");
    rd(4, 2'b11, "R4");
    rd(4, 2'b00, "R4");

    // R2: deselected writes and reads
    step(1'b1, 1'b1, 1'b0, 2'b00, 5, 18'h0ABCD, "R2");
    step(1'b0, 1'b0, 1'b0, 2'b00, 6, 18'h0DCBA, "R2");
    step(1'b1, 1'b0, 1'b1, 2'b00, 5, 18'h0, "R2");
    rd(5, 2'b00, "R2");
    rd(6, 2'b00, "R2");

    // R7: quiet mid-cycle, and writes under quiet
    rd(7, 2'b00, "R7");
    out_quiet = 1'b1; #1 compare("R7");
    out_quiet = 1'b0; #1 compare("R7");
    out_quiet = 1'b1;
    wr(13, 18'h1F0F0, 2'b00, "R7");
    out_quiet = 1'b0;
    rd(13, 2'b00, "R7");

    // R6: two-stage mode
    idle("R6");
    two_stage = 1'b1;
    idle("R6");
    idle("R6");
    for (int a = 0; a < 6; a++) rd(a, 2'b00, "R6");
    rd(20, 2'b00, "R6");
    step(1'b1, 1'b0, 1'b1, 2'b10, 0, 18'h0, "R6");
    step(1'b1, 1'b0, 1'b1, 2'b00, 0, 18'h0, "R6");
    rd(21, 2'b11, "R6");
    step(1'b1, 1'b0, 1'b1, 2'b01, 0, 18'h0, "R6");
    idle("R6");
    wr(22, 18'h12345, 2'b00, "R6");
    rd(22, 2'b00, "R6");
    rd(22, 2'b00, "R6");
    idle("R6");
    random_mix(400, "R6");

    // back to flow-through for a mixed run
    idle("R5");
    two_stage = 1'b0;
    idle("R5");
    random_mix(400, "R5");
    idle("R2");

    done = 1;
    summary();
    $finish;
  end
endmodule